// File: doc/BRIEF.md
# Rank-Order Address Decoder Layer

This block turns a rank-ordered sparse address into a rank-ordered set of active word lines. An address is a list of distinct input indices that arrive in firing order, one per accepted transfer. The first index to arrive is the most important. Each input carries a weight that shrinks geometrically with its firing position. A bank of decoder neurons each owns a fixed binary row over the input space. Each neuron adds up the weights of the address inputs that fall inside its row.

When the last index of the address has been taken, the block selects the decoders with the largest sums. It streams them out strongest first as (decoder index, significance) pairs, and each pair carries a new geometric significance based on its output position. The rows hold only binary weights. The layer still responds to the firing order of the address, because each sum is a sum of position-dependent weights. Both streams use valid/ready. An input index moves when `in_valid` and `in_ready` are both high at a rising edge. An output pair moves when `out_valid` and `out_ready` are both high. While `out_ready` is low, the pair on offer is held unchanged. The block does not accept a new address until the whole winner list has been drained.

Top module: `rod_decoder_layer`

## Requirements
- R1: After reset, `in_ready` is high and `out_valid` and `done` are low. The block accepts exactly ACTIVE (11) indices per address, and `in_ready` stays high while it collects them, including idle cycles. `in_ready` is low from the cycle after the last index is accepted until the final output pair has been taken.
- R2: The input at firing position k (k = 0 first) carries significance s(k). Here s(0) = 65535 and s(k) = floor(s(k-1) * 58982 / 65536), which is a ratio of about 0.9 in 16-bit unsigned fixed point.
- R3: Decoder d owns input i exactly when ((i - b_d) * m_d) mod 256 < 21, with b_d = (37*d + 11) mod 256 and m_d = (74*d + 5) mod 256. This gives every row exactly 21 of the 256 inputs.
- R4: The activation of a decoder is the exact sum of s(k) over the address inputs it owns. The 20-bit accumulator holds that sum without overflow. Each new address starts from zero.
- R5: After the last index, exactly WINNERS (23) pairs are streamed in descending order of activation.
- R6: Among equal activations, the lower decoder index is emitted first.
- R7: The j-th output pair (j = 0 first) carries significance s(j), using the same series as R2.
- R8: While `out_valid` is high and `out_ready` is low, `out_decoder` and `out_sig` stay unchanged and `out_valid` stays high.
- R9: No decoder index appears twice within one output stream. After the last pair, the block returns to collecting.
- R10: `done` is high only in the first cycle of each output stream, which is the cycle in which `out_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input index offered |
| in_ready | output | 1 | Block is collecting indices |
| in_index | input | 8 | Input index, in firing order |
| out_valid | output | 1 | Winner pair offered |
| out_ready | input | 1 | Consumer takes the pair |
| out_decoder | output | 6 | Winning decoder index |
| out_sig | output | 16 | Output significance of this position |
| done | output | 1 | Pulse: address complete, stream starts |

## Verification
The hardest case to reach from the ports is a tie in activation that falls inside the winner list. In that case only the index rule decides the order. Ties come about when several decoders see exactly the same subset of the address at the same positions, and that cannot be forced directly through the address. The stimulus therefore runs many random addresses, plus an address taken from one decoder's own row. The reference model counts how many of its selections were decided by a tie, and the bench requires that count to be non-zero. Random stalls on `out_ready` and random gaps on `in_valid` exercise holding under back-pressure during those same streams.

// File: rtl/rod_pkg.sv
package rod_pkg;

  typedef enum logic { ST_COLLECT = 1'b0, ST_EMIT = 1'b1 } rod_state_e;

  // Geometric significance at position k, unsigned fixed point, top = 2^w-1
  function automatic longint unsigned rod_sig_at(int k, int w, longint unsigned ratio_q);
    longint unsigned s;
    s = (longint'(1) << w) - 1;
    for (int i = 0; i < k; i++) s = (s * ratio_q) >> w;
    return s;
  endfunction

endpackage

// File: rtl/rod_sig_table.sv
module rod_sig_table #(
  parameter int DEPTH   = 23,
  parameter int SIG_W   = 16,
  parameter int RATIO_Q = 58982,
  localparam int RW     = $clog2(DEPTH)
) (
  input  logic [RW-1:0]    rank_a,
  input  logic [RW-1:0]    rank_b,
  output logic [SIG_W-1:0] sig_a,
  output logic [SIG_W-1:0] sig_b
);
  logic [SIG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_entry
    localparam logic [SIG_W-1:0] VAL = SIG_W'(rod_pkg::rod_sig_at(k, SIG_W, RATIO_Q));
    assign tbl[k] = VAL;
  end

  assign sig_a = tbl[rank_a];
  assign sig_b = tbl[rank_b];
endmodule

// File: rtl/rod_accum_bank.sv
module rod_accum_bank #(
  parameter int IN_COUNT  = 256,
  parameter int DEC_COUNT = 64,
  parameter int ROW_ONES  = 21,
  parameter int SIG_W     = 16,
  parameter int ACC_W     = 20,
  parameter int BASE_STEP = 37,
  parameter int BASE_OFS  = 11,
  parameter int MULT_STEP = 74,
  parameter int MULT_OFS  = 5,
  localparam int IDX_W    = $clog2(IN_COUNT)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            en,
  input  logic                            first,
  input  logic [IDX_W-1:0]                index,
  input  logic [SIG_W-1:0]                sig,
  output logic [DEC_COUNT-1:0][ACC_W-1:0] acc
);
  localparam logic [IDX_W:0] ONES_L = (IDX_W+1)'(ROW_ONES);

  for (genvar d = 0; d < DEC_COUNT; d++) begin : g_dec
    localparam logic [IDX_W-1:0] BASE = IDX_W'((d * BASE_STEP + BASE_OFS) % IN_COUNT);
    localparam logic [IDX_W-1:0] MULT = IDX_W'((d * MULT_STEP + MULT_OFS) % IN_COUNT);
    logic [IDX_W-1:0] rel, scaled;
    logic             hit;
    logic [ACC_W-1:0] add;

    assign rel    = index - BASE;
    assign scaled = rel * MULT;
    assign hit    = {1'b0, scaled} < ONES_L;
    assign add    = hit ? ACC_W'(sig) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n)  acc[d] <= '0;
      else if (en) acc[d] <= first ? add : acc[d] + add;
    end
  end
endmodule

// File: rtl/rod_topw_select.sv
module rod_topw_select #(
  parameter int DEC_COUNT = 64,
  parameter int ACC_W     = 20,
  localparam int DEC_W    = $clog2(DEC_COUNT)
) (
  input  logic [DEC_COUNT-1:0][ACC_W-1:0] acc,
  input  logic [DEC_COUNT-1:0]            mask,
  output logic [DEC_W-1:0]                win
);
  logic [ACC_W-1:0] best;
  logic             found;

  // Strict comparison keeps the lowest index among equals
  always_comb begin
    best  = '0;
    found = 1'b0;
    win   = '0;
    for (int d = 0; d < DEC_COUNT; d++) begin
      if (!mask[d] && (!found || acc[d] > best)) begin
        found = 1'b1;
        best  = acc[d];
        win   = DEC_W'(d);
      end
    end
  end
endmodule

// File: rtl/rod_decoder_layer.sv
module rod_decoder_layer #(
  parameter int IN_COUNT  = 256,
  parameter int ACTIVE    = 11,
  parameter int DEC_COUNT = 64,
  parameter int ROW_ONES  = 21,
  parameter int WINNERS   = 23,
  parameter int SIG_W     = 16,
  parameter int RATIO_Q   = 58982,
  localparam int IDX_W    = $clog2(IN_COUNT),
  localparam int DEC_W    = $clog2(DEC_COUNT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IDX_W-1:0] in_index,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DEC_W-1:0] out_decoder,
  output logic [SIG_W-1:0] out_sig,
  output logic             done
);
  import rod_pkg::*;

  localparam int ACC_W     = SIG_W + $clog2(ACTIVE + 1);
  localparam int TBL_DEPTH = (ACTIVE > WINNERS) ? ACTIVE : WINNERS;
  localparam int RANK_W    = $clog2(TBL_DEPTH);
  localparam logic [RANK_W-1:0] LAST_IN  = RANK_W'(ACTIVE - 1);
  localparam logic [RANK_W-1:0] LAST_OUT = RANK_W'(WINNERS - 1);

  rod_state_e                     state;
  logic [RANK_W-1:0]              in_rank, out_rank;
  logic [DEC_COUNT-1:0]           mask;
  logic [DEC_COUNT-1:0][ACC_W-1:0] acc;
  logic [SIG_W-1:0]               in_sig;
  logic [DEC_W-1:0]               win;
  logic                           in_fire, out_fire;

  assign in_ready    = (state == ST_COLLECT);
  assign out_valid   = (state == ST_EMIT);
  assign in_fire     = in_valid && in_ready;
  assign out_fire    = out_valid && out_ready;
  assign out_decoder = win;

  rod_sig_table #(.DEPTH(TBL_DEPTH), .SIG_W(SIG_W), .RATIO_Q(RATIO_Q)) u_sig (
    .rank_a(in_rank), .rank_b(out_rank), .sig_a(in_sig), .sig_b(out_sig)
  );

  rod_accum_bank #(
    .IN_COUNT(IN_COUNT), .DEC_COUNT(DEC_COUNT), .ROW_ONES(ROW_ONES),
    .SIG_W(SIG_W), .ACC_W(ACC_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .en(in_fire), .first(in_rank == '0),
    .index(in_index), .sig(in_sig), .acc(acc)
  );

  rod_topw_select #(.DEC_COUNT(DEC_COUNT), .ACC_W(ACC_W)) u_sel (
    .acc(acc), .mask(mask), .win(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_COLLECT;
      in_rank  <= '0;
      out_rank <= '0;
      mask     <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_COLLECT: if (in_fire) begin
          if (in_rank == LAST_IN) begin
            in_rank  <= '0;
            out_rank <= '0;
            mask     <= '0;
            done     <= 1'b1;
            state    <= ST_EMIT;
          end else begin
            in_rank <= in_rank + 1'b1;
          end
        end
        ST_EMIT: if (out_fire) begin
          mask[win] <= 1'b1;
          if (out_rank == LAST_OUT) state <= ST_COLLECT;
          else out_rank <= out_rank + 1'b1;
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/rod_decoder_layer_chk.sv
module rod_decoder_layer_chk #(
  parameter int ACTIVE    = 11,
  parameter int DEC_COUNT = 64,
  parameter int WINNERS   = 23,
  parameter int SIG_W     = 16,
  localparam int DEC_W    = $clog2(DEC_COUNT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DEC_W-1:0] out_decoder,
  input logic [SIG_W-1:0] out_sig,
  input logic             done
);
  logic [$clog2(ACTIVE+1):0]  acnt;
  logic [$clog2(WINNERS+1):0] ocnt;
  logic [DEC_COUNT-1:0]       seen;
  logic in_fire, out_fire;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acnt <= '0; ocnt <= '0; seen <= '0;
    end else begin
      if (in_fire)  begin acnt <= acnt + 1'b1; ocnt <= '0; seen <= '0; end
      if (out_fire) begin acnt <= '0; ocnt <= ocnt + 1'b1; seen[out_decoder] <= 1'b1; end
    end
  end

  a_r1_full_address: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> acnt == ($clog2(ACTIVE+1)+1)'(ACTIVE));
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  a_r5_stream_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> ocnt == ($clog2(WINNERS+1)+1)'(WINNERS));
  a_r7_sig_falls: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire |=> !out_valid || out_sig < $past(out_sig));
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_decoder) && $stable(out_sig));
  a_r9_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !seen[out_decoder]);
  a_r10_done_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> done);
  a_r10_done_only: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> out_valid && !$past(out_valid));
endmodule

bind rod_decoder_layer rod_decoder_layer_chk #(
  .ACTIVE(ACTIVE), .DEC_COUNT(DEC_COUNT), .WINNERS(WINNERS), .SIG_W(SIG_W)
) u_chk (.*);

// File: tb/rod_decoder_layer_bench.sv
module rod_decoder_layer_bench;
  localparam int NIN = 256, NACT = 11, NDEC = 64, NWIN = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] in_index = '0;
  logic in_ready, out_valid, done;
  logic [5:0] out_decoder;
  logic [15:0] out_sig;

  always #4 clk = ~clk;

  rod_decoder_layer u_rod_decoder_layer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_index(in_index), .out_valid(out_valid), .out_ready(out_ready),
    .out_decoder(out_decoder), .out_sig(out_sig), .done(done)
  );

  int checks = 0, fails = 0, ties = 0;
  bit finished = 0;
  int addr [NACT];
  int exp_dec [NWIN];
  int exp_sig [NWIN];

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // R2/R7 series
  function automatic int sig_ref(int k);
    longint s = 65535;
    for (int i = 0; i < k; i++) s = (s * 58982) / 65536;
    return int'(s);
  endfunction

  // R3 row ownership
  function automatic bit owns(int d, int i);
    int b = (37 * d + 11) % NIN;
    int m = (74 * d + 5) % NIN;
    return ((((i - b + NIN) % NIN) * m) % NIN) < 21;
  endfunction

  task automatic build_expect();
    longint act [NDEC];
    bit used [NDEC];
    for (int d = 0; d < NDEC; d++) begin
      act[d] = 0; used[d] = 0;
      for (int k = 0; k < NACT; k++) if (owns(d, addr[k])) act[d] += sig_ref(k);
    end
    for (int j = 0; j < NWIN; j++) begin
      int best = -1;
      for (int d = 0; d < NDEC; d++)
        if (!used[d] && (best < 0 || act[d] > act[best])) best = d;
      for (int d = best + 1; d < NDEC; d++)
        if (!used[d] && act[d] == act[best]) ties++;
      used[best] = 1;
      exp_dec[j] = best;
      exp_sig[j] = sig_ref(j);
    end
  endtask

  task automatic random_addr();
    for (int k = 0; k < NACT; k++) begin
      bit dup;
      int v;
      do begin
        v = $urandom % NIN; dup = 0;
        for (int q = 0; q < k; q++) if (addr[q] == v) dup = 1;
      end while (dup);
      addr[k] = v;
    end
  endtask

  task automatic run_addr(int gap_pct, int stall_pct);
    int j = 0, cyc = 0;
    build_expect();
    for (int k = 0; k < NACT; k++) begin
      @(negedge clk);
      while (($urandom % 100) < gap_pct) begin
        in_valid = 1'b0;
        check(in_ready == 1'b1, "R1", "in_ready during gap", in_ready, 1);
        @(negedge clk);
      end
      check(in_ready == 1'b1, "R1", "in_ready collecting", in_ready, 1);
      in_valid = 1'b1;
      in_index = 8'(addr[k]);
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (j < NWIN) begin
      bit rdy;
      check(out_valid == 1'b1, "R5", "out_valid", out_valid, 1);
      check(in_ready == 1'b0, "R1", "in_ready emitting", in_ready, 0);
      check(done == (cyc == 0), "R10", "done", done, cyc == 0);
      check(int'(out_decoder) == exp_dec[j], j > 0 ? "R5/R6" : "R4/R5",
            "out_decoder", out_decoder, exp_dec[j]);
      check(int'(out_sig) == exp_sig[j], "R7", "out_sig", out_sig, exp_sig[j]);
      rdy = (($urandom % 100) >= stall_pct);
      out_ready = rdy;
      @(negedge clk);
      if (!rdy) check(int'(out_decoder) == exp_dec[j], "R8", "held decoder", out_decoder, exp_dec[j]);
      if (rdy) j++;
      cyc++;
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R9", "out_valid after stream", out_valid, 0);
    check(in_ready == 1'b1, "R9", "in_ready after stream", in_ready, 1);
    check(done == 1'b0, "R10", "done after stream", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0BAD5EED));
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
    check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    check(done == 1'b0, "R1", "reset done", done, 0);
    rst_n = 1'b1;

    // R3/R4 directed: address drawn from decoder 0's own row
    begin
      int n = 0;
      for (int i = 0; i < NIN && n < NACT; i++) if (owns(0, i)) begin addr[n] = i; n++; end
    end
    run_addr(0, 0);
    check(exp_dec[0] == 0, "R4", "row-0 address top winner model", exp_dec[0], 0);
    // same address reversed: order changes the sums
    for (int k = 0; k < NACT / 2; k++) begin
      int t = addr[k]; addr[k] = addr[NACT-1-k]; addr[NACT-1-k] = t;
    end
    run_addr(30, 40);
    // lowest indices, back-to-back, no stalls
    for (int k = 0; k < NACT; k++) addr[k] = k;
    run_addr(0, 0);
    // constrained random
    for (int r = 0; r < 40; r++) begin
      random_addr();
      run_addr(r % 3 == 0 ? 25 : 0, (r % 4) * 20);
    end
    check(ties > 0, "R6", "tie decisions exercised", ties, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule